// File: doc/BRIEF.md
# Bus Acknowledge Wait-State Generator

This block answers bus cycles on behalf of slow slaves that cannot produce a transfer acknowledge on their own, on an asynchronous bus with active-low strobes. A cycle is qualified when three things hold together: the address strobe is low, at least one of the two byte data strobes is low, and at least one chip-select line is low. The block then runs a clocked delay chain and drives its active-low acknowledge once the number of clocks programmed for the selected chip select has elapsed. The master ends the cycle on that acknowledge.

The acknowledge is a registered output. It stays asserted for as long as the qualified strobe lasts and is withdrawn once the strobes go away, so every transfer gets a complete assert-then-negate handshake. All strobe and request inputs pass through a two-flop synchronizer before use. A single-step mode lets exactly one bus cycle complete for each rising edge on a step-request input. A watchdog signals a bus error if a qualified strobe waits too long without an acknowledge.

Top module: `xferack_gen`

## Requirements
- R1: While reset is asserted and immediately after it is released, both `ackN` and `berrN` are high.
- R2: If `asN`, at least one data strobe and a chip select whose delay is 0 are low, `ackN` goes low after the third rising clock edge, counting the first edge that samples these inputs low as edge one. It is still high after the second such edge.
- R3: A chip select with delay d (0 to 7) gives the acknowledge after rising edge d+3 and not before. Chip select i takes its delay from bits [3i+2:3i] of `CS_DELAYS`. The defaults are 0 for index 0, 2 for index 1, 7 for index 2 and 4 for index 3.
- R4: When the qualifying condition ends (the address strobe goes high, both data strobes go high, or all chip selects go high), `ackN` is still low after the second rising edge that samples the change and is high after the third.
- R5: An address strobe with both data strobes high produces no acknowledge.
- R6: A cycle with all chip-select lines high produces no acknowledge.
- R7: Once `ackN` is low, it stays low for as long as the qualified strobe continues.
- R8: With `stepMode` high, an acknowledge is issued only after a synchronized rising edge of `stepReq` has armed the block. Each arming allows exactly one acknowledge. An arming made while the bus is idle is kept until the next cycle.
- R9: If a qualified strobe stays active with no acknowledge, `berrN` goes low after rising edge `WD_LIMIT`+2 and not before. `ackN` is high whenever `berrN` is low. `berrN` returns high on the third rising edge after the strobe ends.
- R10: When several chip-select lines are low, the delay of the lowest-numbered one applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| asN | input | 1 | Address strobe, active low |
| udsN | input | 1 | Upper byte data strobe, active low |
| ldsN | input | 1 | Lower byte data strobe, active low |
| csN | input | NUM_CS | Chip-select lines, active low |
| stepMode | input | 1 | High selects single-step operation |
| stepReq | input | 1 | Step request; each rising edge arms one acknowledge |
| ackN | output | 1 | Registered transfer acknowledge, active low |
| berrN | output | 1 | Bus error from the watchdog, active low |

## Verification
The hardest states to reach are the ones where a qualified strobe is held for a long time with no acknowledge: the watchdog expiry and the single-step gate. In normal mode every selected cycle is acknowledged within ten clocks. The stimulus therefore switches on step mode and holds a strobe without arming it. It checks that no acknowledge appears, then arms the block with a step pulse in the middle of the cycle. It repeats the starved cycle until the watchdog fires on its exact edge. A separate case arms the block while the bus is idle, to show that the arming is kept until the next cycle.

// File: rtl/xferack_pkg.sv
package xferack_pkg;
  localparam int DELAY_W = 3;

  // control -> datapath strobes
  typedef struct packed {
    logic chainRun;   // advance delay chain, otherwise clear it
    logic wdRun;      // advance watchdog, otherwise clear it
  } xfer_ctrl_t;

  // datapath -> control status
  typedef struct packed {
    logic strobeOn;   // qualified, synchronized bus strobe
    logic tapHit;     // selected delay has elapsed
    logic stepEdge;   // rising edge on synchronized step request
    logic timeout;    // watchdog reached its limit
  } xfer_stat_t;
endpackage

// File: rtl/xferack_dp.sv
module xferack_dp
  import xferack_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter logic [NUM_CS*DELAY_W-1:0] CS_DELAYS = 12'h9D0,
  parameter int WD_LIMIT = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic              udsN,
  input  logic              ldsN,
  input  logic [NUM_CS-1:0] csN,
  input  logic              stepReq,
  input  xfer_ctrl_t        ctrl,
  output xfer_stat_t        stat
);
  localparam int CHAIN_LEN = (1 << DELAY_W) - 1;
  localparam int VEC_W     = NUM_CS + 4;
  localparam int CNT_W     = $clog2(WD_LIMIT + 1);
  localparam logic [VEC_W-1:0] RST_VEC = {{NUM_CS{1'b1}}, 1'b0, 3'b111};
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WD_LIMIT);

  logic [SYNC_STAGES-1:0][VEC_W-1:0] syncPipe;
  logic [VEC_W-1:0]   rawVec, syncOut;
  logic [NUM_CS-1:0]  csOn;
  logic               asOn, dsOn, stepS, stepPrev, csAny;
  logic [DELAY_W-1:0] selDelay;
  logic [CHAIN_LEN-1:0] chain;
  logic [CNT_W-1:0]   wdCnt;

  assign rawVec = {csN, stepReq, ldsN, udsN, asN};

  // two-flop (parameterized) synchronizer for every asynchronous input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= RST_VEC;
    end else begin
      syncPipe[0] <= rawVec;
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign syncOut = syncPipe[SYNC_STAGES-1];
  assign asOn    = ~syncOut[0];
  assign dsOn    = ~syncOut[1] | ~syncOut[2];
  assign stepS   = syncOut[3];
  assign csOn    = ~syncOut[VEC_W-1:4];

  // lowest-numbered active chip select picks the delay
  always_comb begin
    csAny    = 1'b0;
    selDelay = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (csOn[i]) begin
        csAny    = 1'b1;
        selDelay = CS_DELAYS[i*DELAY_W +: DELAY_W];
      end
    end
  end

  // delay chain: fills with ones while the strobe runs, clears otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              chain <= '0;
    else if (ctrl.chainRun) chain <= {chain[CHAIN_LEN-2:0], 1'b1};
    else                    chain <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepPrev <= 1'b0;
    else       stepPrev <= stepS;
  end

  // saturating watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wdCnt <= '0;
    else if (ctrl.wdRun) begin
      if (wdCnt != CNT_MAX) wdCnt <= wdCnt + CNT_W'(1);
    end else wdCnt <= '0;
  end

  assign stat.strobeOn = asOn & dsOn & csAny;
  assign stat.tapHit   = (selDelay == '0) ? stat.strobeOn : chain[selDelay - 1'b1];
  assign stat.stepEdge = stepS & ~stepPrev;
  assign stat.timeout  = (wdCnt == CNT_MAX);
endmodule

// File: rtl/xferack_ctrl.sv
module xferack_ctrl
  import xferack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepMode,
  input  xfer_stat_t stat,
  output xfer_ctrl_t ctrl,
  output logic       ackN,
  output logic       berrN,
  output logic       armed
);
  logic permit, ackSet;

  assign permit = ~stepMode | armed;
  // set on the tap once permitted; hold while the strobe lasts
  assign ackSet = stat.strobeOn & (~ackN | (stat.tapHit & permit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackN  <= 1'b1;
      armed <= 1'b0;
    end else begin
      ackN  <= ~ackSet;
      armed <= stat.stepEdge | (armed & ~(ackSet & ackN));
    end
  end

  assign ctrl.chainRun = stat.strobeOn;
  assign ctrl.wdRun    = stat.strobeOn & ~ackSet;
  assign berrN         = ~stat.timeout;
endmodule

// File: rtl/xferack_gen.sv
module xferack_gen
  import xferack_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter logic [NUM_CS*DELAY_W-1:0] CS_DELAYS = 12'h9D0,
  parameter int WD_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic              udsN,
  input  logic              ldsN,
  input  logic [NUM_CS-1:0] csN,
  input  logic              stepMode,
  input  logic              stepReq,
  output logic              ackN,
  output logic              berrN
);
  xfer_ctrl_t ctrl;
  xfer_stat_t stat;
  logic       armed;

  xferack_dp #(
    .NUM_CS(NUM_CS), .CS_DELAYS(CS_DELAYS), .WD_LIMIT(WD_LIMIT), .SYNC_STAGES(2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .asN(asN), .udsN(udsN), .ldsN(ldsN),
    .csN(csN), .stepReq(stepReq), .ctrl(ctrl), .stat(stat)
  );

  xferack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stepMode(stepMode), .stat(stat),
    .ctrl(ctrl), .ackN(ackN), .berrN(berrN), .armed(armed)
  );
endmodule

// File: rtl/xferack_chk.sv
module xferack_chk (
  input logic clk,
  input logic rstN,
  input logic ackN,
  input logic berrN,
  input logic stepMode,
  input logic armed,
  input logic strobeOn
);
  assert_ack_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> $past(strobeOn));

  assert_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobeOn |=> ackN);

  assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ackN && strobeOn) |=> !ackN);

  assert_step_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stepMode && !armed && ackN) |=> ackN);

  assert_berr_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !berrN |-> ackN);
endmodule

bind xferack_gen xferack_chk u_chk (
  .clk(clk), .rstN(rstN), .ackN(ackN), .berrN(berrN),
  .stepMode(stepMode), .armed(armed), .strobeOn(stat.strobeOn)
);

// File: tb/xferack_gen_tb.sv
`timescale 1ns/1ps
module xferack_gen_tb;
  localparam int WD = 32;

  logic clk = 1'b0;
  logic rstN, asN, udsN, ldsN, stepMode, stepReq;
  logic [3:0] csN;
  logic ackN, berrN;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  xferack_gen #(.NUM_CS(4), .CS_DELAYS(12'h9D0), .WD_LIMIT(WD)) u_dut (
    .clk(clk), .rstN(rstN), .asN(asN), .udsN(udsN), .ldsN(ldsN),
    .csN(csN), .stepMode(stepMode), .stepReq(stepReq),
    .ackN(ackN), .berrN(berrN)
  );

  // {csN[3:0], udsN, ldsN, expected latency in edges (0 = no acknowledge)}
  localparam logic [10:0] VEC [8] = '{
    {4'b1110, 1'b0, 1'b0, 5'd3},   // R2: cs0 delay 0
    {4'b1101, 1'b0, 1'b1, 5'd5},   // R3: cs1 delay 2, upper strobe only
    {4'b1011, 1'b1, 1'b0, 5'd10},  // R3: cs2 delay 7, lower strobe only
    {4'b0111, 1'b0, 1'b0, 5'd7},   // R3: cs3 delay 4
    {4'b1001, 1'b0, 1'b0, 5'd5},   // R10: cs1 and cs2, cs1 wins
    {4'b0000, 1'b0, 1'b0, 5'd3},   // R10: all selected, cs0 wins
    {4'b1111, 1'b0, 1'b0, 5'd0},   // R6: no chip select
    {4'b1110, 1'b1, 1'b1, 5'd0}    // R5: address strobe only
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic startCycle(input logic [3:0] cs, input logic u, input logic l);
    @(negedge clk);
    asN = 1'b0; udsN = u; ldsN = l; csN = cs;
  endtask

  task automatic endCycle();
    asN = 1'b1; udsN = 1'b1; ldsN = 1'b1; csN = 4'hF;
  endtask

  // count edges until the acknowledge shows, up to lim
  task automatic waitAck(input int lim, output int n);
    n = 0;
    while (ackN && n < lim) begin
      @(posedge clk); @(negedge clk); n++;
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    rstN = 1'b0; asN = 1'b1; udsN = 1'b1; ldsN = 1'b1; csN = 4'hF;
    stepMode = 1'b0; stepReq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ackN === 1'b1 && berrN === 1'b1, "R1 outputs in reset", {ackN, berrN}, 3);
    rstN = 1'b1;
    edges(3);
    chk(ackN === 1'b1 && berrN === 1'b1, "R1 outputs after reset", {ackN, berrN}, 3);

    for (int v = 0; v < 8; v++) begin
      logic [10:0] e;
      e = VEC[v];
      startCycle(e[10:7], e[6], e[5]);
      if (e[4:0] == 5'd0) begin
        waitAck(20, lat);
        chk(ackN === 1'b1, $sformatf("R5/R6 no ack vector %0d", v), ackN, 1);
        endCycle();
      end else begin
        waitAck(20, lat);
        chk(lat == int'(e[4:0]), $sformatf("R2/R3/R10 latency vector %0d", v), lat, e[4:0]);
        edges(4);
        chk(ackN === 1'b0, $sformatf("R7 ack held vector %0d", v), ackN, 0);
        endCycle();
        edges(2);
        chk(ackN === 1'b0, $sformatf("R4 release not early vector %0d", v), ackN, 0);
        edges(1);
        chk(ackN === 1'b1, $sformatf("R4 release vector %0d", v), ackN, 1);
      end
      chk(berrN === 1'b1, $sformatf("R9 no berr vector %0d", v), berrN, 1);
      edges(4);
    end

    // R8: single-step, arm in mid-cycle
    @(negedge clk); stepMode = 1'b1;
    edges(2);
    startCycle(4'b1110, 1'b0, 1'b0);
    edges(12);
    chk(ackN === 1'b1, "R8 no ack before step", ackN, 1);
    stepReq = 1'b1;
    edges(3);
    stepReq = 1'b0;
    waitAck(10, lat);
    chk(ackN === 1'b0, "R8 ack after step", ackN, 0);
    endCycle();
    edges(5);
    // R8: second cycle without a new step
    startCycle(4'b1110, 1'b0, 1'b0);
    edges(12);
    chk(ackN === 1'b1, "R8 one ack per step", ackN, 1);
    endCycle();
    edges(5);
    // R8: arm while idle, then run a cycle
    stepReq = 1'b1;
    edges(2);
    stepReq = 1'b0;
    edges(4);
    startCycle(4'b1110, 1'b0, 1'b0);
    waitAck(20, lat);
    chk(lat == 3, "R8 idle arming kept", lat, 3);
    endCycle();
    edges(5);

    // R9: starved cycle until the watchdog fires
    startCycle(4'b1101, 1'b0, 1'b0);
    edges(WD + 1);
    chk(berrN === 1'b1, "R9 berr not early", berrN, 1);
    edges(1);
    chk(berrN === 1'b0, "R9 berr asserted", berrN, 0);
    chk(ackN === 1'b1, "R9 no ack with berr", ackN, 1);
    endCycle();
    edges(3);
    chk(berrN === 1'b1, "R9 berr released", berrN, 1);
    stepMode = 1'b0;
    edges(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule